// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column addresses that the burst visits. A single-cycle start pulse captures a starting column, a burst-length code and an ordering bit. From the following cycle on, the block emits one column per clock with a valid flag, and flags the final beat. The address for each beat is formed inside an aligned block whose size equals the burst length. The low bits either count upward and wrap, or are XORed with the beat index. The upper bits stay fixed.

Full-page bursts walk the whole row and wrap from the top column to column zero. They end only when a stop request arrives. A stop request ends a burst of any length, and a new start pulse during a burst cuts the running burst and reloads the counter.

Control is a two-state machine. `S_IDLE` emits nothing. `S_RUN` emits one beat per cycle. The transitions are:
- GO: `S_IDLE` to `S_RUN` on a start pulse.
- ADVANCE: `S_RUN` to `S_RUN` when the burst continues.
- RELOAD: `S_RUN` to `S_RUN` on a start pulse during a burst.
- FINISH: `S_RUN` to `S_IDLE` after the final beat of a fixed-length burst.
- HALT: `S_RUN` to `S_IDLE` after a beat on which stop was requested.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it, until the first start pulse, `valid_o`, `last_o` and `type_err_o` are low.
- R2: The length code `blen_i` maps as follows: 3'b000 is 1 beat, 3'b001 is 2 beats, 3'b010 is 4 beats, 3'b011 is 8 beats and 3'b111 is a full page of 1024 beats. The reserved codes 3'b100 to 3'b110 act as 1 beat.
- R3: For 2, 4 and 8 beats, the upper column bits (all bits above bit 0, 1 or 2 respectively) equal those of the start column on every beat of the burst.
- R4: With `btype_i`=0 (sequential), the low bits of beat k are (start offset + k) modulo the burst length.
- R5: With `btype_i`=1 (interleaved), the low bits of beat k are start offset XOR k.
- R6: A full-page burst counts upward one column per beat and wraps from 1023 to 0. It stays valid past 1024 beats until a stop is taken.
- R7: A full-page burst requested with `btype_i`=1 runs sequentially, and `type_err_o` is high on every beat of that burst.
- R8: A 1-beat burst emits exactly the start column once, whatever `btype_i` is.
- R9: When `stop_i` is high on a valid beat and `start_i` is low, that beat shows `last_o` high and `valid_o` is low in the next cycle, at any burst length.
- R10: On the final beat of a fixed-length burst `last_o` is high, and `valid_o` falls in the next cycle.
- R11: A start pulse during a burst ends it. The new burst's first beat appears in the next cycle, and start takes priority over a stop in the same cycle.
- R12: The first beat appears in the cycle after the clock edge that samples `start_i`, and equals the start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle burst request |
| start_col_i | input | COL_W | Starting column |
| blen_i | input | 3 | Burst-length code |
| btype_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented on `col_o` |
| last_o | output | 1 | The current beat is the final one |
| type_err_o | output | 1 | Full-page burst was requested with interleaved ordering |

## Verification
The address forming is driven with start offsets that are non-zero and sit inside blocks with non-zero upper bits. Both orderings are applied at 2, 4 and 8 beats. Some of these offsets make sequential and interleaved orders diverge, and others make them coincide, so a swapped or mis-masked block shows up as a wrong column rather than a lucky match. A reserved length code and 1-beat bursts with both ordering bits separate the single-beat path from the general one.

Full-page bursts are started near the top of the row to expose the 1023-to-0 wrap. One is run past 1024 beats to show that it does not end by itself. The remaining cases cover:
- an interleaved full-page request, which must run sequentially and raise the error flag;
- stops in mid-burst;
- a restart that lands in the same cycle as a stop.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int LEN_CODE_W = 3;

    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'b000;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'b111;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } bcg_state_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o
);

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        unique case (code_i)
            LEN_TWO:   mask_o = COL_W'(1);
            LEN_FOUR:  mask_o = COL_W'(3);
            LEN_EIGHT: mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:   mask_o = '0;
        endcase
    end

endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;
    logic [COL_W-1:0] off;

    assign seq_off = base_i + beat_i;
    assign ilv_off = base_i ^ beat_i;
    assign off     = ilv_i ? ilv_off : seq_off;

    // Each bit comes from the moving offset inside the block, else from the fixed base.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? off[b] : base_i[b];
    end

endmodule

// File: rtl/bcg_seq_fsm.sv
module bcg_seq_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             btype_i,
    input  logic [COL_W-1:0] dec_mask_i,
    input  logic             dec_full_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    bcg_state_t       state_q, state_d;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic             err_q;
    logic             at_end;

    assign at_end = !full_q && (beat_q == mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_RUN;              // GO
            S_RUN: begin
                if (start_i)               state_d = S_RUN;    // RELOAD
                else if (stop_i || at_end) state_d = S_IDLE;   // HALT / FINISH
                else                       state_d = S_RUN;    // ADVANCE
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                beat_q <= '0;
                base_q <= start_col_i;
                mask_q <= dec_mask_i;
                full_q <= dec_full_i;
                ilv_q  <= btype_i && !dec_full_i;
                err_q  <= btype_i && dec_full_i;
            end else if (state_q == S_RUN) begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    always_comb begin
        valid_o = (state_q == S_RUN);
        last_o  = valid_o && (at_end || stop_i);
        err_o   = valid_o && err_q;
        base_o  = base_q;
        beat_o  = beat_q;
        mask_o  = mask_q;
        ilv_o   = ilv_q;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] blen_i,
    input  logic                  btype_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  type_err_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             ilv;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    bcg_seq_fsm #(.COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .btype_i     (btype_i),
        .dec_mask_i  (dec_mask),
        .dec_full_i  (dec_full),
        .stop_i      (stop_i),
        .base_o      (base),
        .beat_o      (beat),
        .mask_o      (mask),
        .ilv_o       (ilv),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .err_o       (type_err_o)
    );

    bcg_addr_form #(.COL_W(COL_W)) u_addr (
        .base_i (base),
        .beat_i (beat),
        .mask_i (mask),
        .ilv_i  (ilv),
        .col_o  (col_o)
    );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             type_err_o
);

    p_first_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    p_err_only_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        type_err_o |-> valid_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!last_o && !type_err_o));

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .type_err_o  (type_err_o)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             btype_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             type_err_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .btype_i     (btype_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .type_err_o  (type_err_o)
    );

    typedef struct packed {
        logic [9:0]      col;
        logic [2:0]      len;
        logic            tp;
        logic [3:0]      n;
        logic [7:0][9:0] exp;   // exp[k] is beat k
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'd26,   3'b010, 1'b0, 4'd4, {10'd0, 10'd0, 10'd0, 10'd0, 10'd25, 10'd24, 10'd27, 10'd26}},
        '{10'd61,   3'b011, 1'b1, 4'd8, {10'd58, 10'd59, 10'd56, 10'd57, 10'd62, 10'd63, 10'd60, 10'd61}},
        '{10'd8,    3'b001, 1'b1, 4'd2, {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd9, 10'd8}},
        '{10'd1023, 3'b000, 1'b1, 4'd1, {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd1023}},
        '{10'd3,    3'b011, 1'b0, 4'd8, {10'd2, 10'd1, 10'd0, 10'd7, 10'd6, 10'd5, 10'd4, 10'd3}},
        '{10'd257,  3'b010, 1'b1, 4'd4, {10'd0, 10'd0, 10'd0, 10'd0, 10'd258, 10'd259, 10'd256, 10'd257}},
        '{10'd100,  3'b101, 1'b0, 4'd1, {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd100}},
        '{10'd7,    3'b001, 1'b0, 4'd2, {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd6, 10'd7}}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int col, input logic [2:0] len, input logic tp);
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        blen_i      = len;
        btype_i     = tp;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", valid_o, 0);
        chk("R1 last in reset", last_o, 0);
        chk("R1 err in reset", type_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", valid_o, 0);

        // R2 R3 R4 R5 R8 R10 R12: table walk
        foreach (VECS[i]) begin
            launch(VECS[i].col, VECS[i].len, VECS[i].tp);
            for (int k = 0; k < VECS[i].n; k++) begin
                chk("R2 R3 R4 R5 R12 column", col_o, VECS[i].exp[k]);
                chk("R2 valid", valid_o, 1);
                chk("R10 last", last_o, (k == VECS[i].n - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R10 idle after burst", valid_o, 0);
        end

        // R6: full page near top, wrap, then stop (R9)
        launch(1020, 3'b111, 1'b0);
        for (int k = 0; k < 6; k++) begin
            chk("R6 page column", col_o, (1020 + k) % 1024);
            chk("R6 page no last", last_o, 0);
            @(negedge clk);
        end
        stop_i = 1'b1;
        #1;
        chk("R9 last on stop", last_o, 1);
        chk("R9 stop beat column", col_o, 2);
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 idle after stop", valid_o, 0);

        // R6: full page past 1024 beats
        launch(40, 3'b111, 1'b0);
        repeat (1024) @(negedge clk);
        chk("R6 valid past page", valid_o, 1);
        chk("R6 column back at start", col_o, 40);
        @(negedge clk);
        chk("R6 next after lap", col_o, 41);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 page idle", valid_o, 0);

        // R7: full page interleaved falls back to sequential with error
        launch(5, 3'b111, 1'b1);
        chk("R7 first", col_o, 5);
        chk("R7 err", type_err_o, 1);
        @(negedge clk);
        chk("R7 sequential second", col_o, 6);
        chk("R7 err held", type_err_o, 1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R7 err cleared when idle", type_err_o, 0);

        // R9: stop a fixed 8-beat burst on beat 2
        launch(16, 3'b011, 1'b0);
        @(negedge clk);
        @(negedge clk);
        stop_i = 1'b1;
        #1;
        chk("R9 fixed stop column", col_o, 18);
        chk("R9 fixed stop last", last_o, 1);
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 fixed idle", valid_o, 0);

        // R11: restart with simultaneous stop
        launch(0, 3'b011, 1'b0);
        @(negedge clk);
        start_i     = 1'b1;
        stop_i      = 1'b1;
        start_col_i = 10'd41;
        blen_i      = 3'b001;
        btype_i     = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk("R11 reload first", col_o, 41);
        chk("R11 reload valid", valid_o, 1);
        @(negedge clk);
        chk("R11 reload second", col_o, 40);
        chk("R11 reload last", last_o, 1);
        @(negedge clk);
        chk("R11 reload idle", valid_o, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule